// File: doc/BRIEF.md
# Programmable Waveform Sequencer

The sequencer plays a short program of waveform vectors that paces byte transfers between an on-chip FIFO and an external byte-wide device. Each vector sets the levels of three control outputs. A vector either holds for a set number of clocks, or tests the two ready inputs on every clock and picks one of two successor vectors. When a vector completes it can pulse a FIFO-advance strobe and an address-increment strobe. A vector that uses the FIFO strobe waits while the FIFO cannot take part in the transfer, and the pending transfer goes ahead once the FIFO is ready.

A start pulse loads a 32-bit transaction count and runs the program from vector 0. A step whose chosen successor is index 7 ends the waveform and decrements the count. While transactions remain, the program restarts at vector 0. When the count reaches zero the block returns to idle and pulses done. The abort input returns the block to idle at once, with the control outputs at a level set by software. The vector memory is loaded through an address, data and write-enable port.

States: `S_IDLE` (control outputs at the idle level, waits for start), `S_STEP` (a vector is executing), `S_STALL` (a FIFO step has finished its timing and waits for FIFO readiness). Transitions: start (`S_IDLE`→`S_STEP`, or a zero-count start, which stays in `S_IDLE` and pulses done), stall (`S_STEP`→`S_STALL`), resume (`S_STALL`→`S_STEP`), advance (`S_STEP`→`S_STEP` at a new vector or at vector 0), finish (→`S_IDLE` on the last transaction), abort (any→`S_IDLE`).

Top module: `wave_seq_engine`

## Requirements
- R1: A write with `wr_en_i` high stores `wr_data_i` at `wr_addr_i` on the clock edge. The vector word is 23 bits: hold count [7:0], false successor [10:8], true successor [13:11], ready polarity [14], ready select [16:15], branch enable [17], address-increment request [18], FIFO-advance request [19], control levels [22:20]. All entries reset to zero.
- R2: `start_i` in idle loads `tc_load_i` into the transaction count. If that value is nonzero, the block leaves idle and executes vector 0 in the next cycle. `start_i` has no effect while the block is running.
- R3: In idle, or in any cycle with `abort_i` high, `ctl_o` equals `idle_ctl_i`. Otherwise `ctl_o` equals the control field of the current vector, so it can change on every clock.
- R4: A step with branch enable at 0 lasts hold+1 cycles, then goes to its true successor.
- R5: A step with branch enable at 1 evaluates a condition on every cycle. Ready select 0 uses rdy[0], 1 uses rdy[1], 2 uses rdy[0] AND rdy[1], and 3 uses rdy[0] OR rdy[1]. The condition is met when this value equals the polarity bit. A met condition selects the true successor and an unmet one the false successor. Selecting its own index means the step waits, and a wait is not a completion.
- R6: `fifo_adv_o` and `addr_inc_o` each pulse for exactly the cycle in which a step with the matching request bit completes. They are never high in idle.
- R7: A completing step with the FIFO request set needs the FIFO to be ready: not empty when `dir_i`=0, not full when `dir_i`=1. While the FIFO is not ready, the step stalls with its control levels held and its chosen successor kept. It completes in the first cycle the FIFO is ready.
- R8: A completion whose successor is 7 decrements the count, and `tc_o` shows the remaining count. Execution restarts at vector 0 while the count before the decrement was above 1.
- R9: When the last transaction completes, the block enters idle and `done_o` is high for the following cycle with `tc_o` at 0. A start with a zero count gives the same done pulse without leaving idle.
- R10: With `abort_i` high, no strobe fires and no count changes, and the block is idle in the next cycle with no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Vector memory write enable |
| wr_addr_i | input | 3 | Vector memory write index |
| wr_data_i | input | 23 | Vector word to store |
| start_i | input | 1 | Start pulse |
| abort_i | input | 1 | Return to idle at once |
| tc_load_i | input | 32 | Transaction count loaded at start |
| dir_i | input | 1 | 0: FIFO supplies data, 1: FIFO receives data |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fifo_full_i | input | 1 | FIFO full flag |
| rdy_i | input | 2 | Ready inputs from the external device |
| idle_ctl_i | input | 3 | Control levels driven when idle |
| ctl_o | output | 3 | Control outputs |
| fifo_adv_o | output | 1 | FIFO advance strobe |
| addr_inc_o | output | 1 | Address increment strobe |
| tc_o | output | 32 | Remaining transaction count |
| done_o | output | 1 | Pulse when the count reaches zero |
| idle_o | output | 1 | Block is idle |

## Verification
The assertions assume that the vector memory is not rewritten while a waveform runs. The stall check relies on this: it expects the control levels to stay constant across stalled cycles. The assertions also assume that every input is synchronous to the clock and known after reset, and that a program is built so that the end index 7 is only ever a successor and never an executing step. The stimulus writes vectors only while the block is idle, and it changes the ready inputs and FIFO flags pseudo-randomly once per cycle, away from the clock edge. Start and abort are one-cycle pulses.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;
    localparam int CTL_W   = 3;
    localparam int IDX_W   = 3;
    localparam int HOLD_W  = 8;
    localparam int SEL_W   = 2;
    localparam int DEPTH   = 1 << IDX_W;
    localparam int END_IDX = DEPTH - 1;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic              fifo_adv;
        logic              addr_inc;
        logic              branch_en;
        logic [SEL_W-1:0]  rdy_sel;
        logic              rdy_pol;
        logic [IDX_W-1:0]  nxt_true;
        logic [IDX_W-1:0]  nxt_false;
        logic [HOLD_W-1:0] hold;
    } wvec_t;

    localparam int VEC_W = $bits(wvec_t);

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_STEP  = 2'd1,
        S_STALL = 2'd2
    } seq_state_e;
endpackage

// File: rtl/wave_vec_mem.sv
module wave_vec_mem
    import wave_seq_pkg::*;
#(
    parameter int DEPTH_P = DEPTH,
    parameter int AW      = IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [VEC_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output wvec_t            rd_vec
);
    logic [VEC_W-1:0] store [DEPTH_P];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH_P; i++) begin
                store[i] <= '0;
            end
        end else if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    assign rd_vec = wvec_t'(store[rd_addr]);

    // R1
    wr_addr_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$isunknown(wr_addr));
endmodule

// File: rtl/wave_rdy_eval.sv
module wave_rdy_eval
    import wave_seq_pkg::*;
(
    input  logic [1:0]       rdy,
    input  logic [SEL_W-1:0] sel,
    input  logic             pol,
    output logic             hit
);
    logic level;

    always_comb begin
        unique case (sel)
            2'd0:    level = rdy[0];
            2'd1:    level = rdy[1];
            2'd2:    level = rdy[0] & rdy[1];
            default: level = rdy[0] | rdy[1];
        endcase
        hit = ~(level ^ pol);
    end
endmodule

// File: rtl/wave_xfer_cnt.sv
module wave_xfer_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] value,
    output logic         last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (dec) begin
            value <= value - W'(1);
        end
    end

    assign last = (value == W'(1));

    // R8
    cnt_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (value != '0));
endmodule

// File: rtl/wave_seq_engine.sv
module wave_seq_engine
    import wave_seq_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_addr_i,
    input  logic [VEC_W-1:0] wr_data_i,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic [CNT_W-1:0] tc_load_i,
    input  logic             dir_i,
    input  logic             fifo_empty_i,
    input  logic             fifo_full_i,
    input  logic [1:0]       rdy_i,
    input  logic [CTL_W-1:0] idle_ctl_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic             fifo_adv_o,
    output logic             addr_inc_o,
    output logic [CNT_W-1:0] tc_o,
    output logic             done_o,
    output logic             idle_o
);
    localparam logic [IDX_W-1:0] END_CODE = IDX_W'(END_IDX);

    seq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  ptr_q, ptr_d;
    logic [IDX_W-1:0]  pend_q, pend_d;
    logic [HOLD_W-1:0] timer_q, timer_d;
    logic              done_q, done_d;

    wvec_t             vec;
    logic              hit;
    logic [IDX_W-1:0]  tgt;
    logic [IDX_W-1:0]  commit_tgt;
    logic              finishing;
    logic              fifo_ok;
    logic              commit;
    logic              cnt_load;
    logic              cnt_dec;
    logic              cnt_last;

    wave_vec_mem u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .rd_addr (ptr_q),
        .rd_vec  (vec)
    );

    wave_rdy_eval u_rdy (
        .rdy (rdy_i),
        .sel (vec.rdy_sel),
        .pol (vec.rdy_pol),
        .hit (hit)
    );

    wave_xfer_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (tc_load_i),
        .dec      (cnt_dec),
        .value    (tc_o),
        .last     (cnt_last)
    );

    // step decode
    always_comb begin
        if (vec.branch_en) begin
            tgt       = hit ? vec.nxt_true : vec.nxt_false;
            finishing = (tgt != ptr_q);
        end else begin
            tgt       = vec.nxt_true;
            finishing = (timer_q == vec.hold);
        end
        fifo_ok = dir_i ? !fifo_full_i : !fifo_empty_i;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ptr_q   <= '0;
            pend_q  <= '0;
            timer_q <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            pend_q  <= pend_d;
            timer_q <= timer_d;
            done_q  <= done_d;
        end
    end

    // next state
    always_comb begin
        state_d    = state_q;
        ptr_d      = ptr_q;
        pend_d     = pend_q;
        timer_d    = timer_q;
        done_d     = 1'b0;
        cnt_load   = 1'b0;
        cnt_dec    = 1'b0;
        commit     = 1'b0;
        commit_tgt = tgt;

        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    cnt_load = 1'b1;
                    if (tc_load_i == '0) begin
                        done_d = 1'b1;
                    end else begin
                        state_d = S_STEP;
                        ptr_d   = '0;
                        timer_d = '0;
                    end
                end
            end
            S_STEP: begin
                if (finishing) begin
                    if (vec.fifo_adv && !fifo_ok) begin
                        state_d = S_STALL;
                        pend_d  = tgt;
                    end else begin
                        commit = 1'b1;
                    end
                end else if (!vec.branch_en) begin
                    timer_d = timer_q + HOLD_W'(1);
                end
            end
            S_STALL: begin
                if (fifo_ok) begin
                    commit     = 1'b1;
                    commit_tgt = pend_q;
                end
            end
            default: state_d = S_IDLE;
        endcase

        if (commit) begin
            timer_d = '0;
            if (commit_tgt == END_CODE) begin
                cnt_dec = 1'b1;
                if (cnt_last) begin
                    state_d = S_IDLE;
                    done_d  = 1'b1;
                end else begin
                    state_d = S_STEP;
                    ptr_d   = '0;
                end
            end else begin
                state_d = S_STEP;
                ptr_d   = commit_tgt;
            end
        end

        if (abort_i) begin
            state_d  = S_IDLE;
            done_d   = 1'b0;
            cnt_load = 1'b0;
            cnt_dec  = 1'b0;
            commit   = 1'b0;
        end
    end

    // outputs
    always_comb begin
        ctl_o      = (state_q == S_IDLE || abort_i) ? idle_ctl_i : vec.ctl;
        fifo_adv_o = commit & vec.fifo_adv;
        addr_inc_o = commit & vec.addr_inc;
        idle_o     = (state_q == S_IDLE);
        done_o     = done_q;
    end

    // R2
    start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && start_i && !abort_i && tc_load_i != '0) |=> !idle_o);

    // R6
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (!fifo_adv_o && !addr_inc_o));

    // R7
    stall_ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STALL && $past(state_q == S_STALL)) |-> $stable(ctl_o));

    // R9
    done_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (idle_o && tc_o == '0));

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (idle_o && !done_o));
endmodule

// File: tb/wave_seq_engine_tb_top.sv
module wave_seq_engine_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [22:0] wr_data = '0;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [31:0] tcl = '0;
    logic        dir = 1'b0;
    logic        f_empty = 1'b0;
    logic        f_full = 1'b0;
    logic [1:0]  rdy = '0;
    logic [2:0]  idle_ctl = 3'b101;
    logic [2:0]  ctl;
    logic        fadv, ainc, done, idle;
    logic [31:0] tc;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    logic [22:0] mmem [8];
    int          m_state = 0;
    int          m_ptr = 0;
    int          m_timer = 0;
    int          m_pend = 0;
    logic [31:0] m_cnt = '0;
    bit          m_done = 0;

    always #2 clk = ~clk;

    wave_seq_engine dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .start_i(start), .abort_i(abort),
        .tc_load_i(tcl), .dir_i(dir), .fifo_empty_i(f_empty),
        .fifo_full_i(f_full), .rdy_i(rdy), .idle_ctl_i(idle_ctl),
        .ctl_o(ctl), .fifo_adv_o(fadv), .addr_inc_o(ainc), .tc_o(tc),
        .done_o(done), .idle_o(idle)
    );

    function automatic logic [22:0] mkvec(int c, int fa, int ai, int br, int sel,
                                          int pol, int nt, int nf, int hold);
        return 23'((c << 20) | (fa << 19) | (ai << 18) | (br << 17) |
                   (sel << 15) | (pol << 14) | (nt << 11) | (nf << 8) | hold);
    endfunction

    task automatic chk(string req, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h", req, tag, what, act, exp);
        end
    endtask

    task automatic tick(string tag);
        logic [22:0] v;
        int c, fa, ai, br, sel, pol, nt, nf, hold, tgt, ctgt;
        bit lvl, fok, fin, commit, nd;
        #1;
        for (int k = 0; k < 8; k++) begin
            if (^mmem[k] === 1'bx) mmem[k] = '0;
        end
        v    = mmem[m_ptr];
        c    = int'(v[22:20]);  fa = int'(v[19]); ai = int'(v[18]);
        br   = int'(v[17]);     sel = int'(v[16:15]); pol = int'(v[14]);
        nt   = int'(v[13:11]);  nf = int'(v[10:8]); hold = int'(v[7:0]);
        case (sel)
            0: lvl = rdy[0];
            1: lvl = rdy[1];
            2: lvl = rdy[0] & rdy[1];
            default: lvl = rdy[0] | rdy[1];
        endcase
        tgt = (br != 0) ? ((lvl == pol[0]) ? nt : nf) : nt;
        fok = dir ? !f_full : !f_empty;
        fin = 0; commit = 0; ctgt = tgt;
        if (m_state == 1) fin = (br != 0) ? (tgt != m_ptr) : (m_timer == hold);
        if (!abort && rst_n) begin
            if (m_state == 1 && fin && !(fa != 0 && !fok)) commit = 1;
            if (m_state == 2 && fok) begin commit = 1; ctgt = m_pend; end
        end

        chk("R3", tag, "ctl", 32'(ctl), (m_state == 0 || abort) ? 32'(idle_ctl) : 32'(c));
        chk("R6", tag, "fifo_adv", 32'(fadv), 32'(commit && fa != 0));
        chk("R6", tag, "addr_inc", 32'(ainc), 32'(commit && ai != 0));
        chk("R8", tag, "count", tc, m_cnt);
        chk("R9", tag, "done", 32'(done), 32'(m_done));
        chk("R2", tag, "idle", 32'(idle), 32'(m_state == 0));

        // model update at the coming edge
        nd = 0;
        if (!rst_n) begin
            m_state = 0; m_ptr = 0; m_timer = 0; m_pend = 0; m_cnt = '0;
            for (int k = 0; k < 8; k++) mmem[k] = '0;
        end else begin
            if (abort) begin
                m_state = 0;
            end else begin
                if (m_state == 0 && start) begin
                    m_cnt = tcl;
                    if (tcl == 0) nd = 1;
                    else begin m_state = 1; m_ptr = 0; m_timer = 0; end
                end else if (m_state == 1 && !commit) begin
                    if (fin) begin m_state = 2; m_pend = tgt; end
                    else if (br == 0) m_timer = (m_timer + 1) & 255;
                end
                if (commit) begin
                    m_timer = 0;
                    if (ctgt == 7) begin
                        if (m_cnt == 1) begin m_state = 0; nd = 1; end
                        else begin m_state = 1; m_ptr = 0; end
                        m_cnt = m_cnt - 1;
                    end else begin
                        m_state = 1; m_ptr = ctgt;
                    end
                end
            end
            if (wr_en) mmem[wr_addr] = wr_data;
        end
        m_done = nd;
        @(negedge clk);
    endtask

    task automatic wr(int a, logic [22:0] d);
        wr_en = 1; wr_addr = 3'(a); wr_data = d;
        tick("R1");
        wr_en = 0;
    endtask

    task automatic run_wave(logic [31:0] n, bit d, int pct, string tag);
        dir = d; tcl = n; start = 1;
        tick(tag);
        start = 0;
        for (int i = 0; i < 600; i++) begin
            rdy = 2'($urandom);
            if (d) f_full = (($urandom % 100) < pct);
            else   f_empty = (($urandom % 100) < pct);
            tick(tag);
            if (m_state == 0) break;
        end
        f_empty = 0; f_full = 0;
        tick(tag);
    endtask

    initial begin
        @(negedge clk);
        tick("R2"); tick("R2");
        rst_n = 1;
        tick("R2");

        // program A: hold step, strobing step, branch wait on rdy[0]
        wr(0, mkvec(1, 0, 0, 0, 0, 0, 1, 0, 2));
        wr(1, mkvec(2, 1, 1, 0, 0, 0, 2, 0, 0));
        wr(2, mkvec(4, 0, 0, 1, 0, 1, 7, 2, 0));
        run_wave(3, 0, 20, "R4");
        run_wave(2, 0, 70, "R7");
        run_wave(3, 1, 60, "R7");
        run_wave(5, 0, 10, "R8");

        // start while busy, then abort
        tcl = 50; start = 1; tick("R2"); start = 0;
        for (int i = 0; i < 10; i++) begin rdy = 2'($urandom); tick("R2"); end
        tcl = 5; start = 1; tick("R2"); start = 0;
        for (int i = 0; i < 10; i++) begin rdy = 2'($urandom); tick("R10"); end
        abort = 1; tick("R10"); abort = 0;
        tick("R10"); tick("R10");
        chk("R10", "abort", "idle after abort", 32'(idle), 32'd1);

        // zero count start
        tcl = 0; start = 1; tick("R9"); start = 0;
        chk("R9", "zero", "done after zero count", 32'(done), 32'd1);
        tick("R9");

        // program B: AND with low polarity, then OR, then rdy[1]
        wr(2, mkvec(4, 0, 1, 1, 2, 0, 3, 2, 0));
        wr(3, mkvec(6, 1, 0, 0, 0, 0, 7, 0, 1));
        run_wave(4, 1, 30, "R5");
        wr(2, mkvec(3, 1, 0, 1, 3, 1, 3, 2, 0));
        run_wave(3, 0, 30, "R5");
        wr(2, mkvec(7, 0, 0, 1, 1, 0, 3, 2, 0));
        run_wave(3, 0, 0, "R5");
        wr(0, mkvec(5, 0, 1, 0, 0, 0, 3, 0, 0));
        run_wave(4, 0, 0, "R4");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #700000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule